// File: doc/BRIEF.md
# USB OUT Endpoint Receive Buffer

This block holds the data stage of host-to-device packets for a single USB OUT endpoint. The packet layer upstream marks the start of a data packet together with its DATA0/DATA1 parity, then delivers payload bytes with a one-cycle valid strobe. It closes the packet with an end strobe that carries the CRC verdict. The block stores the payload in a 64-entry byte buffer and checks the data toggle itself. It answers each packet with a handshake code that the transmitter upstream turns into ACK, NAK or silence.

A packet is committed only when it is complete, its CRC is good, it fits in the buffer and its toggle matches the expected one. A committed packet raises a data-available flag. The flag stays set until the controller re-arms the endpoint by writing a one to it, and while it is set every further packet is refused with NAK. The controller first reads the length register. It then drains the payload from one data address, and each read of that address returns the next byte.

Top module: `usb_out_ep_buf`

## Requirements
- R1: The register read port has three addresses: 0 returns the committed byte count, 1 pops the data byte, and 2 returns status with data-available in bit 0. Read data appears on `reg_rdata` in the cycle after the read strobe and holds until the next read.
- R2: A packet is committed only at its end strobe, and only if `rx_crc_ok` is 1, the packet has at most 64 bytes, its parity matches the expected toggle and data-available was clear at its start. In the cycle after that end strobe, `irq_dav` is 1 and `hs_vld` is 1 with `hs_code` = 2'b01 (ACK).
- R3: The count register returns the payload length of the last committed packet, from 0 to 64. It reads 0 after reset and after a re-arm.
- R4: Successive reads of address 1 return the committed bytes in arrival order, one byte per read.
- R5: A register write to address 2 with bit 0 set clears data-available and zeroes the count and read position. A write with bit 0 clear has no effect.
- R6: The expected toggle is even (`rx_pid_odd` = 0) after reset and flips on each commit. A good-CRC packet with the wrong parity gets ACK but is discarded: data-available, count and expected toggle stay unchanged.
- R7: A good-CRC packet that starts while data-available is set gets `hs_code` = 2'b10 (NAK). It leaves the buffer contents, the count and the expected toggle untouched.
- R8: A packet ending with `rx_crc_ok` = 0 gets no handshake (`hs_vld` stays 0) and changes neither data-available, count, readable data nor expected toggle.
- R9: A read of address 1 when every committed byte has already been read returns 0 and does not advance the read position.
- R10: A packet longer than 64 bytes gets no handshake and is discarded like a CRC failure.
- R11: After reset, `irq_dav` and `hs_vld` are 0 and the status and count registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sop | input | 1 | Start of an OUT data packet |
| rx_pid_odd | input | 1 | Packet parity with `rx_sop`: 0 = DATA0, 1 = DATA1 |
| rx_byte_vld | input | 1 | Payload byte strobe |
| rx_byte | input | 8 | Payload byte |
| rx_eop | input | 1 | End of packet |
| rx_crc_ok | input | 1 | CRC verdict, valid with `rx_eop` |
| hs_vld | output | 1 | Handshake pulse, one cycle after `rx_eop` |
| hs_code | output | 2 | 01 = ACK, 10 = NAK |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_dav | output | 1 | Data-available flag |

## Verification
The handshake pulse, the data-available flag and the new count are all due in the cycle after the end strobe, because all three are registered at that single edge. Register read data is due in the cycle after the read strobe. The bench drives every input on the falling clock edge. It samples each result on the next falling edge, so every check falls exactly one register stage after its stimulus. The bench sweeps every payload length from 0 to 64 and reads each packet back in full plus one extra read. It then sends toggle errors, CRC errors, refused packets and an oversize packet, and checks that the observable state is unchanged afterwards.

// File: rtl/usb_oep_pkg.sv
package usb_oep_pkg;
  typedef enum logic [1:0] {
    HS_NONE = 2'b00,
    HS_ACK  = 2'b01,
    HS_NAK  = 2'b10
  } hs_code_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'b00,
    RX_RECV  = 2'b01,
    RX_BLOCK = 2'b10
  } rx_state_e;

  localparam logic [1:0] ADDR_COUNT  = 2'd0;
  localparam logic [1:0] ADDR_DATA   = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
endpackage

// File: rtl/oep_rst_sync.sv
module oep_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/oep_buf_mem.sv
module oep_buf_mem #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/oep_rx_ctrl.sv
module oep_rx_ctrl
  import usb_oep_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_sop,
  input  logic          rx_pid_odd,
  input  logic          rx_byte_vld,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_eop,
  input  logic          rx_crc_ok,
  input  logic          dav,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic          commit,
  output logic [CW-1:0] commit_len,
  output logic          hs_vld,
  output hs_code_e      hs_code
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  rx_state_e     state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          ovf_q, ovf_n;
  logic          podd_q, podd_n;
  logic          exp_q, exp_n;
  logic          hsv_q, hsv_n;
  hs_code_e      hsc_q, hsc_n;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    ovf_n   = ovf_q;
    podd_n  = podd_q;
    exp_n   = exp_q;
    hsv_n   = 1'b0;
    hsc_n   = HS_NONE;
    commit  = 1'b0;
    if (rx_sop) begin
      state_n = dav ? RX_BLOCK : RX_RECV;
      cnt_n   = '0;
      ovf_n   = 1'b0;
      podd_n  = rx_pid_odd;
    end else if (rx_eop && state_q != RX_IDLE) begin
      state_n = RX_IDLE;
      if (!rx_crc_ok) begin
        hsv_n = 1'b0;
      end else if (state_q == RX_BLOCK) begin
        hsv_n = 1'b1;
        hsc_n = HS_NAK;
      end else if (!ovf_q) begin
        hsv_n = 1'b1;
        hsc_n = HS_ACK;
        if (podd_q == exp_q) begin
          commit = 1'b1;
          exp_n  = ~exp_q;
        end
      end
    end else if (rx_byte_vld && state_q == RX_RECV) begin
      if (cnt_q == FULL) ovf_n = 1'b1;
      else               cnt_n = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      podd_q  <= 1'b0;
      exp_q   <= 1'b0;
      hsv_q   <= 1'b0;
      hsc_q   <= HS_NONE;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      ovf_q   <= ovf_n;
      podd_q  <= podd_n;
      exp_q   <= exp_n;
      hsv_q   <= hsv_n;
      hsc_q   <= hsc_n;
    end
  end

  assign mem_we     = rx_byte_vld && !rx_sop && !rx_eop &&
                      (state_q == RX_RECV) && (cnt_q != FULL);
  assign mem_waddr  = cnt_q[AW-1:0];
  assign mem_wdata  = rx_byte;
  assign commit_len = cnt_q;
  assign hs_vld     = hsv_q;
  assign hs_code    = hsc_q;
endmodule

// File: rtl/oep_reg_if.sv
module oep_reg_if
  import usb_oep_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          commit,
  input  logic [CW-1:0] commit_len,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_raddr,
  output logic [DW-1:0] reg_rdata,
  output logic          dav,
  output logic [CW-1:0] byte_cnt,
  output logic [CW-1:0] rd_ptr
);
  logic          dav_q, dav_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] ptr_q, ptr_n;
  logic [DW-1:0] rdata_q, rdata_n;
  logic          rdata_en;
  logic          pop, rearm;

  assign pop   = reg_rd && (reg_addr == ADDR_DATA) && (ptr_q < cnt_q);
  assign rearm = reg_wr && (reg_addr == ADDR_STATUS) && reg_wdata[0];

  always_comb begin
    dav_n = dav_q;
    cnt_n = cnt_q;
    ptr_n = ptr_q;
    if (commit) begin
      dav_n = 1'b1;
      cnt_n = commit_len;
      ptr_n = '0;
    end else if (rearm) begin
      dav_n = 1'b0;
      cnt_n = '0;
      ptr_n = '0;
    end else if (pop) begin
      ptr_n = ptr_q + CW'(1);
    end
  end

  assign rdata_en = reg_rd;

  always_comb begin
    rdata_n = '0;
    case (reg_addr)
      ADDR_COUNT:  rdata_n = DW'(cnt_q);
      ADDR_DATA:   rdata_n = pop ? mem_rdata : '0;
      ADDR_STATUS: rdata_n = DW'(dav_q);
      default:     rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dav_q <= 1'b0;
      cnt_q <= '0;
      ptr_q <= '0;
    end else begin
      dav_q <= dav_n;
      cnt_q <= cnt_n;
      ptr_q <= ptr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_n;
  end

  assign mem_raddr = ptr_q[AW-1:0];
  assign reg_rdata = rdata_q;
  assign dav       = dav_q;
  assign byte_cnt  = cnt_q;
  assign rd_ptr    = ptr_q;
endmodule

// File: rtl/usb_out_ep_buf.sv
module usb_out_ep_buf
  import usb_oep_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_sop,
  input  logic          rx_pid_odd,
  input  logic          rx_byte_vld,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_eop,
  input  logic          rx_crc_ok,
  output logic          hs_vld,
  output logic [1:0]    hs_code,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_dav
);
  logic          rst_n_int;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          commit;
  logic [CW-1:0] commit_len;
  logic [CW-1:0] byte_cnt, rd_ptr;
  hs_code_e      hs_code_e_w;

  oep_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  oep_rx_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .rx_sop      (rx_sop),
    .rx_pid_odd  (rx_pid_odd),
    .rx_byte_vld (rx_byte_vld),
    .rx_byte     (rx_byte),
    .rx_eop      (rx_eop),
    .rx_crc_ok   (rx_crc_ok),
    .dav         (irq_dav),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr),
    .mem_wdata   (mem_wdata),
    .commit      (commit),
    .commit_len  (commit_len),
    .hs_vld      (hs_vld),
    .hs_code     (hs_code_e_w)
  );

  oep_buf_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  oep_reg_if #(.DEPTH(DEPTH), .DW(DW)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .commit     (commit),
    .commit_len (commit_len),
    .mem_rdata  (mem_rdata),
    .mem_raddr  (mem_raddr),
    .reg_rdata  (reg_rdata),
    .dav        (irq_dav),
    .byte_cnt   (byte_cnt),
    .rd_ptr     (rd_ptr)
  );

  assign hs_code = hs_code_e_w;
endmodule

// File: rtl/oep_chk.sv
module oep_chk
  import usb_oep_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hs_vld,
  input logic [1:0]    hs_code,
  input logic          irq_dav,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic [CW-1:0] byte_cnt,
  input logic [CW-1:0] rd_ptr,
  input logic          mem_we
);
  // R2
  dav_rise_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_dav) |-> (hs_vld && hs_code == HS_ACK));

  // R2
  hs_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_vld |-> (hs_code == HS_ACK || hs_code == HS_NAK));

  // R5
  rearm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_STATUS && reg_wdata[0] && irq_dav) |=> !irq_dav);

  // R7
  nak_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_vld && hs_code == HS_NAK) |-> $stable(byte_cnt));

  // R7
  no_write_while_dav_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !irq_dav);

  // R9
  past_end_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr == ADDR_DATA && rd_ptr >= byte_cnt)
      |=> (reg_rdata == '0 && $stable(rd_ptr)));

  // R9
  ptr_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= byte_cnt);

  // R3
  count_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= CW'(DEPTH));
endmodule

bind usb_out_ep_buf oep_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hs_vld    (hs_vld),
  .hs_code   (hs_code),
  .irq_dav   (irq_dav),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .byte_cnt  (byte_cnt),
  .rd_ptr    (rd_ptr),
  .mem_we    (mem_we)
);

// File: tb/tb_usb_out_ep_buf.sv
module tb_usb_out_ep_buf;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int WATCHDOG = 150000;

  logic       clk;
  logic       rst_n;
  logic       rx_sop, rx_pid_odd, rx_byte_vld, rx_eop, rx_crc_ok;
  logic [7:0] rx_byte;
  logic       hs_vld;
  logic [1:0] hs_code;
  logic       reg_rd, reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq_dav;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit exp_tog = 1'b0;
  bit done = 1'b0;

  usb_out_ep_buf dut (
    .clk(clk), .rst_n(rst_n),
    .rx_sop(rx_sop), .rx_pid_odd(rx_pid_odd), .rx_byte_vld(rx_byte_vld),
    .rx_byte(rx_byte), .rx_eop(rx_eop), .rx_crc_ok(rx_crc_ok),
    .hs_vld(hs_vld), .hs_code(hs_code),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_dav(irq_dav)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(int i, int seed);
    return 8'((i * 37 + seed * 11 + 5) % 256);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_pkt(int n, bit odd, bit crc, int seed,
                          output bit hv, output logic [1:0] hc);
    rx_sop = 1'b1; rx_pid_odd = odd;
    @(negedge clk);
    rx_sop = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_byte_vld = 1'b1; rx_byte = pat(i, seed);
      @(negedge clk);
    end
    rx_byte_vld = 1'b0;
    rx_eop = 1'b1; rx_crc_ok = crc;
    @(negedge clk);
    rx_eop = 1'b0; rx_crc_ok = 1'b0;
    hv = hs_vld; hc = hs_code;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_back(int n, int seed, string req);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      rd_reg(2'd1, d);
      chk(d == pat(i, seed), req, d, pat(i, seed));
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    bit hv;
    logic [1:0] hc;
    logic [7:0] d;
    rx_sop = 0; rx_pid_odd = 0; rx_byte_vld = 0; rx_byte = 0;
    rx_eop = 0; rx_crc_ok = 0;
    reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk(irq_dav == 1'b0, "R11 dav", irq_dav, 0);
    chk(hs_vld == 1'b0, "R11 hs_vld", hs_vld, 0);
    rd_reg(2'd2, d); chk(d == 8'd0, "R11 status", d, 0);
    rd_reg(2'd0, d); chk(d == 8'd0, "R11 count", d, 0);
    rd_reg(2'd1, d); chk(d == 8'd0, "R9 empty read", d, 0);

    // R1 R2 R3 R4 R9 R5: sweep every length
    for (int n = 0; n <= DEPTH; n++) begin
      send_pkt(n, exp_tog, 1'b1, n, hv, hc);
      chk(hv && hc == 2'b01, "R2 ack", {hv, hc}, 5);
      chk(irq_dav == 1'b1, "R2 dav", irq_dav, 1);
      exp_tog = ~exp_tog;
      rd_reg(2'd2, d); chk(d == 8'd1, "R1 status", d, 1);
      rd_reg(2'd0, d); chk(d == 8'(n), "R3 count", d, n);
      read_back(n, n, "R4 data");
      rd_reg(2'd1, d); chk(d == 8'd0, "R9 past end", d, 0);
      rd_reg(2'd0, d); chk(d == 8'(n), "R9 count kept", d, n);
      wr_reg(2'd2, 8'h01);
      chk(irq_dav == 1'b0, "R5 rearm", irq_dav, 0);
      rd_reg(2'd0, d); chk(d == 8'd0, "R5 count zero", d, 0);
    end

    // R6 wrong toggle: acked, discarded
    send_pkt(5, ~exp_tog, 1'b1, 90, hv, hc);
    chk(hv && hc == 2'b01, "R6 ack on mismatch", {hv, hc}, 5);
    chk(irq_dav == 1'b0, "R6 no dav", irq_dav, 0);
    rd_reg(2'd0, d); chk(d == 8'd0, "R6 count", d, 0);
    send_pkt(7, exp_tog, 1'b1, 91, hv, hc);
    chk(irq_dav == 1'b1, "R6 toggle kept", irq_dav, 1);
    exp_tog = ~exp_tog;

    // R7 refused while dav set; R5 zero write no effect
    wr_reg(2'd2, 8'h00);
    chk(irq_dav == 1'b1, "R5 zero write", irq_dav, 1);
    send_pkt(12, exp_tog, 1'b1, 92, hv, hc);
    chk(hv && hc == 2'b10, "R7 nak", {hv, hc}, 6);
    chk(irq_dav == 1'b1, "R7 dav held", irq_dav, 1);
    rd_reg(2'd0, d); chk(d == 8'd7, "R7 count", d, 7);
    read_back(7, 91, "R7 data kept");
    wr_reg(2'd2, 8'hFF);
    send_pkt(3, exp_tog, 1'b1, 93, hv, hc);
    chk(hv && hc == 2'b01 && irq_dav, "R7 toggle unchanged", irq_dav, 1);
    exp_tog = ~exp_tog;
    read_back(2, 93, "R4 partial");
    wr_reg(2'd2, 8'h01);
    rd_reg(2'd1, d); chk(d == 8'd0, "R5 ptr zero", d, 0);

    // R8 bad CRC
    send_pkt(10, exp_tog, 1'b0, 94, hv, hc);
    chk(hv == 1'b0, "R8 no hs", hv, 0);
    chk(irq_dav == 1'b0, "R8 dav", irq_dav, 0);
    rd_reg(2'd0, d); chk(d == 8'd0, "R8 count", d, 0);
    rd_reg(2'd1, d); chk(d == 8'd0, "R8 data", d, 0);
    send_pkt(4, exp_tog, 1'b1, 95, hv, hc);
    chk(irq_dav == 1'b1, "R8 toggle kept", irq_dav, 1);
    exp_tog = ~exp_tog;
    send_pkt(4, exp_tog, 1'b0, 96, hv, hc);
    chk(hv == 1'b0, "R8 no hs while dav", hv, 0);
    rd_reg(2'd0, d); chk(d == 8'd4, "R8 count held", d, 4);
    read_back(4, 95, "R8 data held");
    wr_reg(2'd2, 8'h01);

    // R10 oversize
    send_pkt(DEPTH + 1, exp_tog, 1'b1, 97, hv, hc);
    chk(hv == 1'b0, "R10 no hs", hv, 0);
    chk(irq_dav == 1'b0, "R10 no dav", irq_dav, 0);
    rd_reg(2'd0, d); chk(d == 8'd0, "R10 count", d, 0);
    send_pkt(DEPTH, exp_tog, 1'b1, 98, hv, hc);
    chk(hv && irq_dav, "R10 toggle kept", irq_dav, 1);
    read_back(DEPTH, 98, "R1 full buffer");
    wr_reg(2'd2, 8'h01);

    done = 1'b1;
    finish_run();
  end
endmodule